// File: doc/BRIEF.md
# Burst Radix-2 Inverse FFT Engine

This block computes an N-point inverse FFT with as little hardware as possible. It accepts one scalar complex sample per cycle into a frame buffer. Once the buffer holds a complete frame, the block runs all log2(N) decimation-in-frequency passes in place. Every pass goes through one shared complex butterfly with a twiddle multiplier. Each butterfly output is halved, so the block applies an overall scale of 1/N and its output stays in the same amplitude range as its input.

Results stream out contiguously and carry a frame start flag and a frame end flag. The output order is bit-reversed.

A ready output holds the upstream source off while the engine computes. Ready returns during unloading, and the next frame is written into the same buffer behind the read pointer. A source that sees ready fall one cycle late may still present one sample in that cycle. The block keeps that sample as the first sample of the next frame.

Top module: `ifft_burst_engine`

## Requirements
- R1: After reset, ready_o is 1 and valid_o, start_o and end_o are 0.
- R2: For a frame X[0..N-1] (16-bit two's complement real and imaginary parts), each output value matches x[n] = (1/N)·Σ X[m]·e^(+j2πmn/N) within log2(N)+2 LSB in both parts. Twiddles use W-2 fractional bits and each butterfly halves its outputs with floor rounding.
- R3: The k-th output sample of a frame is x[n], where n is k with its log2(N) index bits reversed.
- R4: The N outputs of a frame appear on N consecutive cycles with valid_o = 1. start_o is 1 only with the first of them and end_o is 1 only with the last.
- R5: ready_o is 1 while a frame is being loaded. It is 0 from the cycle after the N-th sample is accepted, through the computation and the first unload cycle. It returns to 1 in the second unload cycle.
- R6: A valid_i sample presented while ready_o is 0 is ignored, with the single exception of R7.
- R7: A sample presented with valid_i = 1 in the first cycle of ready_o = 0 is kept as sample 0 of the next frame. That frame then needs only N-1 further samples.
- R8: From the first cycle with ready_o = 0 to the first cycle with valid_o = 1, exactly log2(N)·(N/2+1)+1 cycles elapse.
- R9: Samples of the next frame accepted during unloading do not alter the outputs of the frame being unloaded.
- R10: Input samples may arrive with idle cycles between them, and the result is the same as for contiguous input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input sample qualifier |
| data_re_i | input | W | Input real part, signed |
| data_im_i | input | W | Input imaginary part, signed |
| ready_o | output | 1 | A sample may be presented |
| valid_o | output | 1 | Output sample qualifier |
| data_re_o | output | W | Output real part, signed |
| data_im_o | output | W | Output imaginary part, signed |
| start_o | output | 1 | First output of a frame |
| end_o | output | 1 | Last output of a frame |

## Verification
The bench builds the engine with N = 16 and W = 16. This gives four passes, so the index reversal and the per-pass twiddle stride are both non-trivial, and the interleaved butterfly addresses change with every pass. The 16-bit width leaves enough fractional resolution for the result to be compared against a real-valued inverse transform with a tolerance of a few LSB. The frame is short enough that back-to-back frames can be run with the early sample, with input gaps, and with samples ignored while the engine computes. The load and unload overlap and the fixed ready-to-output latency of 37 cycles are measured directly.

// File: rtl/ifft_pkg.sv
package ifft_pkg;

  typedef enum logic [1:0] {ST_LOAD, ST_CALC, ST_OUT} eng_state_e;

  // Fixed-point sample of exp(+j*2*pi*k/n), rounded to nearest
  function automatic int tw_fix(int k, int n, int frac, bit want_sin);
    real ang, v;
    ang = 2.0 * 3.14159265358979 * real'(k) / real'(n);
    v = want_sin ? $sin(ang) : $cos(ang);
    v = v * real'(1 << frac);
    return (v < 0.0) ? $rtoi(v - 0.5) : $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/ifft_twiddle_rom.sv
module ifft_twiddle_rom #(
  parameter int N  = 16,
  parameter int W  = 16,
  localparam int IW = $clog2(N) - 1
) (
  input  logic [IW-1:0]       idx_i,
  output logic signed [W-1:0] cos_o,
  output logic signed [W-1:0] sin_o
);
  logic signed [W-1:0] cos_t [N/2];
  logic signed [W-1:0] sin_t [N/2];

  for (genvar k = 0; k < N/2; k++) begin : g_tw
    localparam int C = ifft_pkg::tw_fix(k, N, W-2, 1'b0);
    localparam int S = ifft_pkg::tw_fix(k, N, W-2, 1'b1);
    assign cos_t[k] = W'(C);
    assign sin_t[k] = W'(S);
  end

  assign cos_o = cos_t[idx_i];
  assign sin_o = sin_t[idx_i];
endmodule

// File: rtl/ifft_bfly.sv
module ifft_bfly #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_re_i,
  input  logic signed [W-1:0] a_im_i,
  input  logic signed [W-1:0] b_re_i,
  input  logic signed [W-1:0] b_im_i,
  input  logic signed [W-1:0] tw_c_i,
  input  logic signed [W-1:0] tw_s_i,
  output logic signed [W-1:0] s_re_o,
  output logic signed [W-1:0] s_im_o,
  output logic signed [W-1:0] d_re_o,
  output logic signed [W-1:0] d_im_o
);
  localparam int PW = 2*W + 2;

  logic signed [W:0]    sr, si, dr, di;
  logic signed [PW-1:0] pr, pi;

  assign sr = (W+1)'(a_re_i) + (W+1)'(b_re_i);
  assign si = (W+1)'(a_im_i) + (W+1)'(b_im_i);
  assign dr = (W+1)'(a_re_i) - (W+1)'(b_re_i);
  assign di = (W+1)'(a_im_i) - (W+1)'(b_im_i);

  // conjugated twiddle: (dr + j di)(c + j s)
  assign pr = PW'(dr) * PW'(tw_c_i) - PW'(di) * PW'(tw_s_i);
  assign pi = PW'(dr) * PW'(tw_s_i) + PW'(di) * PW'(tw_c_i);

  // halve sums; drop W-2 twiddle fraction bits plus one halving bit
  assign s_re_o = sr[W:1];
  assign s_im_o = si[W:1];
  assign d_re_o = pr[2*W-2:W-1];
  assign d_im_o = pi[2*W-2:W-1];

  logic unused_bits;
  assign unused_bits = ^{sr[0], si[0], pr[PW-1:2*W-1], pr[W-2:0], pi[PW-1:2*W-1], pi[W-2:0]};
endmodule

// File: rtl/ifft_frame_ram.sv
module ifft_frame_ram #(
  parameter int N  = 16,
  parameter int DW = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  input  logic          we0_i,
  input  logic [AW-1:0] wa0_i,
  input  logic [DW-1:0] wd0_i,
  input  logic          we1_i,
  input  logic [AW-1:0] wa1_i,
  input  logic [DW-1:0] wd1_i
);
  logic [DW-1:0] mem [N];

  assign rd_a_o = mem[ra_a_i];
  assign rd_b_o = mem[ra_b_i];

  always_ff @(posedge clk_i) begin
    if (we0_i) mem[wa0_i] <= wd0_i;
    if (we1_i) mem[wa1_i] <= wd1_i;
  end

  // R2
  write_port_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we0_i && we1_i) |-> (wa0_i != wa1_i));
endmodule

// File: rtl/ifft_burst_engine.sv
module ifft_burst_engine
  import ifft_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] data_re_i,
  input  logic signed [W-1:0] data_im_i,
  output logic                ready_o,
  output logic                valid_o,
  output logic signed [W-1:0] data_re_o,
  output logic signed [W-1:0] data_im_o,
  output logic                start_o,
  output logic                end_o
);
  localparam int L   = $clog2(N);
  localparam int AW  = L;
  localparam int BW  = L - 1;
  localparam int PSW = $clog2(L);
  localparam int DW  = 2*W;

  eng_state_e    state;
  logic [AW-1:0] wr_cnt, rd_cnt, ia, ic, lo, tw_x, ra_a, wa0, p_a, p_c;
  logic [BW-1:0] bf;
  logic [PSW-1:0] pass;
  logic          drain, hold_vld, p_vld, we0;
  logic [DW-1:0] hold_d, rd_a, rd_b, p_xa, p_xb, wd0, wd1;
  logic signed [W-1:0] tw_c, tw_s, p_tc, p_ts, s_re, s_im, d_re, d_im;
  logic          accept, load_last, calc_first, hold_wr;

  assign ready_o    = (state == ST_LOAD) || (state == ST_OUT && rd_cnt != '0);
  assign accept     = valid_i && ready_o;
  assign load_last  = accept && (wr_cnt == AW'(N-1));
  assign calc_first = (state == ST_CALC) && (pass == '0) && (bf == '0) && !drain;
  assign hold_wr    = (state == ST_OUT) && (rd_cnt == '0) && hold_vld;

  // DIF butterfly addressing: span = 2^(L-1-pass)
  always_comb begin
    int sh;
    sh   = L - 1 - int'(pass);
    lo   = AW'(bf) & ((AW'(1) << sh) - AW'(1));
    ia   = ((AW'(bf) >> sh) << (sh + 1)) | lo;
    ic   = ia | (AW'(1) << sh);
    tw_x = lo << pass;
  end

  assign ra_a = (state == ST_CALC) ? ia : rd_cnt;

  always_comb begin
    we0 = 1'b0;
    wa0 = wr_cnt;
    wd0 = {data_re_i, data_im_i};
    if (p_vld) begin
      we0 = 1'b1;
      wa0 = p_a;
      wd0 = {s_re, s_im};
    end else if (hold_wr) begin
      we0 = 1'b1;
      wa0 = '0;
      wd0 = hold_d;
    end else if (accept) begin
      we0 = 1'b1;
    end
  end
  assign wd1 = {d_re, d_im};

  ifft_frame_ram #(.N(N), .DW(DW)) u_ram (
    .clk_i, .rst_ni,
    .ra_a_i(ra_a), .ra_b_i(ic), .rd_a_o(rd_a), .rd_b_o(rd_b),
    .we0_i(we0), .wa0_i(wa0), .wd0_i(wd0),
    .we1_i(p_vld), .wa1_i(p_c), .wd1_i(wd1)
  );

  ifft_twiddle_rom #(.N(N), .W(W)) u_tw (
    .idx_i(tw_x[AW-2:0]), .cos_o(tw_c), .sin_o(tw_s)
  );

  ifft_bfly #(.W(W)) u_bfly (
    .a_re_i(p_xa[DW-1:W]), .a_im_i(p_xa[W-1:0]),
    .b_re_i(p_xb[DW-1:W]), .b_im_i(p_xb[W-1:0]),
    .tw_c_i(p_tc), .tw_s_i(p_ts),
    .s_re_o(s_re), .s_im_o(s_im), .d_re_o(d_re), .d_im_o(d_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_LOAD;
      wr_cnt    <= '0;
      rd_cnt    <= '0;
      bf        <= '0;
      pass      <= '0;
      drain     <= 1'b0;
      hold_vld  <= 1'b0;
      hold_d    <= '0;
      p_vld     <= 1'b0;
      p_a       <= '0;
      p_c       <= '0;
      p_xa      <= '0;
      p_xb      <= '0;
      p_tc      <= '0;
      p_ts      <= '0;
      valid_o   <= 1'b0;
      start_o   <= 1'b0;
      end_o     <= 1'b0;
      data_re_o <= '0;
      data_im_o <= '0;
    end else begin
      p_vld   <= 1'b0;
      valid_o <= 1'b0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
      if (accept) wr_cnt <= wr_cnt + AW'(1);
      if (hold_wr) begin
        wr_cnt   <= AW'(1);
        hold_vld <= 1'b0;
      end
      unique case (state)
        ST_LOAD: if (load_last) state <= ST_CALC;
        ST_CALC: begin
          if (calc_first && valid_i) begin
            hold_vld <= 1'b1;
            hold_d   <= {data_re_i, data_im_i};
          end
          if (!drain) begin
            p_vld <= 1'b1;
            p_a   <= ia;
            p_c   <= ic;
            p_xa  <= rd_a;
            p_xb  <= rd_b;
            p_tc  <= tw_c;
            p_ts  <= tw_s;
            if (bf == BW'(N/2 - 1)) drain <= 1'b1;
            else                    bf    <= bf + BW'(1);
          end else begin
            // one bubble lets the last write land before the next pass reads
            drain <= 1'b0;
            bf    <= '0;
            if (pass == PSW'(L-1)) begin
              pass   <= '0;
              rd_cnt <= '0;
              state  <= ST_OUT;
            end else begin
              pass <= pass + PSW'(1);
            end
          end
        end
        ST_OUT: begin
          valid_o   <= 1'b1;
          data_re_o <= rd_a[DW-1:W];
          data_im_o <= rd_a[W-1:0];
          start_o   <= (rd_cnt == '0);
          end_o     <= (rd_cnt == AW'(N-1));
          rd_cnt    <= rd_cnt + AW'(1);
          if (rd_cnt == AW'(N-1)) state <= load_last ? ST_CALC : ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  logic unused_tw;
  assign unused_tw = tw_x[AW-1];

  // R4
  start_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) start_o |-> valid_o);
  // R4
  end_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) end_o |-> valid_o);
  // R4
  out_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !end_o) |=> valid_o);
  // R4
  first_out_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> start_o);
  // R5
  calc_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) p_vld |-> !ready_o);
  // R9
  load_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_OUT && load_last) |-> (rd_cnt == AW'(N-1)));
endmodule

// File: tb/tb_ifft_burst_engine.sv
`timescale 1ns/1ps
module tb_ifft_burst_engine;
  localparam int  N   = 16;
  localparam int  W   = 16;
  localparam int  L   = 4;
  localparam real TOL = real'(L + 2);
  localparam int  LAT = L * (N/2 + 1) + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [W-1:0] data_re_i = '0, data_im_i = '0;
  logic ready_o, valid_o, start_o, end_o;
  logic signed [W-1:0] data_re_o, data_im_o;

  always #2.5 clk = ~clk;

  ifft_burst_engine #(.N(N), .W(W)) dut (
    .clk_i(clk), .rst_ni, .valid_i, .data_re_i, .data_im_i,
    .ready_o, .valid_o, .data_re_o, .data_im_o, .start_o, .end_o
  );

  int errs = 0, checks = 0;
  int fr [N];
  int fi [N];
  real exp_re [$];
  real exp_im [$];
  int  exp_pos [$];
  int  seed = 12345;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int brev(input int v);
    int r = 0;
    for (int i = 0; i < L; i++) if (v[i]) r |= 1 << (L-1-i);
    return r;
  endfunction

  function automatic int lcg();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) % 4001) - 2000;
  endfunction

  task automatic fill(input int pat);
    for (int m = 0; m < N; m++) begin fr[m] = 0; fi[m] = 0; end
    case (pat)
      0: fr[0] = 4000;
      1: fr[1] = 3200;
      2: begin fr[3] = 1600; fi[5] = -1600; fr[12] = -800; end
      default: for (int m = 0; m < N; m++) begin fr[m] = lcg(); fi[m] = lcg(); end
    endcase
  endtask

  // scoreboard driver side: expected outputs in emitted (index-reversed) order
  task automatic push_expect();
    for (int k = 0; k < N; k++) begin
      int n;
      real sr, si, ang;
      n = brev(k);
      sr = 0.0; si = 0.0;
      for (int m = 0; m < N; m++) begin
        ang = 2.0 * 3.14159265358979 * real'(m * n) / real'(N);
        sr += real'(fr[m]) * $cos(ang) - real'(fi[m]) * $sin(ang);
        si += real'(fr[m]) * $sin(ang) + real'(fi[m]) * $cos(ang);
      end
      exp_re.push_back(sr / real'(N));
      exp_im.push_back(si / real'(N));
      exp_pos.push_back(k);
    end
  endtask

  task automatic drive_sample(input int i);
    while (!ready_o) @(negedge clk);
    valid_i = 1'b1; data_re_i = W'(fr[i]); data_im_i = W'(fi[i]);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic send_frame(input int first, input int gap);
    for (int i = first; i < N; i++) begin
      drive_sample(i);
      if (i != N-1) repeat (gap) @(negedge clk);
    end
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_re.size() == 0) begin
        check(1'b0, "R4", "unexpected output sample", 1, 0);
      end else begin
        real er, ei, dre, dim;
        int  pos;
        er = exp_re.pop_front(); ei = exp_im.pop_front(); pos = exp_pos.pop_front();
        dre = real'(data_re_o) - er; dim = real'(data_im_o) - ei;
        // R2 R3: value at index-reversed position
        check(dre <= TOL && dre >= -TOL, "R2/R3", "re", int'(data_re_o), $rtoi(er));
        check(dim <= TOL && dim >= -TOL, "R2/R3", "im", int'(data_im_o), $rtoi(ei));
        // R4 frame flags
        check(start_o == (pos == 0), "R4", "start_o", int'(start_o), int'(pos == 0));
        check(end_o == (pos == N-1), "R4", "end_o", int'(end_o), int'(pos == N-1));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wait_drain();
    int n = 0;
    while (exp_re.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(exp_re.size() == 0, "R4", "outputs pending", exp_re.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int c;
    bit rdy_before;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check(ready_o == 1'b1, "R1", "ready_o after reset", int'(ready_o), 1);
    check(valid_o == 1'b0 && start_o == 1'b0 && end_o == 1'b0, "R1", "outputs after reset",
          int'({valid_o, start_o, end_o}), 0);

    // R2 constant output from a single DC bin
    fill(0); push_expect(); send_frame(0, 0); wait_drain();

    // R5 R8: ready timing and ready-to-output latency
    fill(1); push_expect(); send_frame(0, 0);
    check(ready_o == 1'b0, "R5", "ready_o after N-th sample", int'(ready_o), 0);
    c = 0; rdy_before = 1'b0;
    while (!valid_o && c < 1000) begin
      rdy_before = rdy_before | ready_o;
      @(negedge clk); c++;
    end
    check(c == LAT, "R8", "ready-low to valid cycles", c, LAT);
    check(rdy_before == 1'b0, "R5", "ready_o rose before unload", int'(rdy_before), 0);
    check(ready_o == 1'b1, "R5", "ready_o in second unload cycle", int'(ready_o), 1);
    wait_drain();

    // R6: samples offered while ready is low (after the first low cycle) are ignored
    fill(2); push_expect(); send_frame(0, 0);
    @(negedge clk);
    for (int g = 0; g < 10; g++) begin
      valid_i = 1'b1; data_re_i = 16'sd9999; data_im_i = -16'sd9999;
      @(negedge clk);
    end
    valid_i = 1'b0;
    fill(3); push_expect(); send_frame(0, 0); wait_drain();

    // R7 R9: early sample, then the rest loaded while the previous frame unloads
    fill(4); push_expect(); send_frame(0, 0);
    fill(5); push_expect();
    valid_i = 1'b1; data_re_i = W'(fr[0]); data_im_i = W'(fi[0]);
    @(negedge clk);
    valid_i = 1'b0;
    send_frame(1, 0);
    fill(6); push_expect(); send_frame(0, 0);
    wait_drain();

    // R10: gaps between input samples
    fill(7); push_expect(); send_frame(0, 3); wait_drain();
    fill(1); push_expect(); send_frame(0, 1); wait_drain();

    finish_run();
  end
endmodule